// File: doc/BRIEF.md
# SPI Register Slave

This block is the serial front end of a timekeeping macro. A host reaches a 128-location byte-wide register space through a four-wire serial link. The link uses clock polarity 0 and clock phase 1, and its chip select is active high. Every transfer opens with a command byte. Bit 7 of that byte chooses write (1) or read (0), and bits 6:0 give the starting location. Each further byte reads or writes the next location.

The block keeps the control, status and trickle-charge registers and a 96-byte scratch RAM. Locations 0x00 to 0x0E belong to the counters and alarms, which live outside this block. For those locations it forwards the address, write data and a one-cycle write strobe, and it returns the value the external logic drives back. Control bit 6 is a write lock. While it is set, only the control register accepts writes.

All serial pins pass through a synchronizer and are sampled on the system clock, so every register sits in a single clock domain. The serial clock must stay well below the system clock. The bench runs it at one sixteenth of the system clock.

Top module: `spi_reg_slave`

## Requirements
- R1: The first byte after chip select rises is a command. Bit 7 set means write and bit 7 clear means read. Bits 6:0 give the first location accessed.
- R2: Each data byte that follows the command accesses the next location. The first data byte uses the commanded location, the second uses that location plus one, and so on.
- R3: Auto-increment wraps within its region. After 0x7F the next location is 0x20. After 0x1F the next location is 0x00.
- R4: Bits move MSB first. The host changes MOSI after the rising serial edge, and the block samples it on the falling edge. During a read data byte the block drives MISO after each rising edge. MISO is 0 during the command byte and during writes.
- R5: Chip select is active high. Dropping it in the middle of a byte abandons that byte without a write, and the next byte after chip select rises again is a command.
- R6: While control bit 6 is 1, writes to every location other than the control register at 0x0F have no effect. A write to 0x0F is always accepted, and writing 0 to bit 6 releases the lock.
- R7: Control bits 5:3 always read 0, and the control register resets to 0x00. Status (0x10) bits 7:2 always read 0.
- R8: A write to the trickle register (0x11) is stored only if its bits 7:4 are 1010. Any other write sets the register to the disabled value 0x00. The register resets to 0x00 and is driven on `trickle_o`.
- R9: Locations 0x20 through 0x7F form a 96-byte RAM that reads back what was written.
- R10: A write to a location 0x00 to 0x0E raises `ext_we_o` for one system-clock cycle, with `ext_addr_o` holding the location and `ext_wdata_o` holding the byte. A read of such a location returns `ext_rdata_i`.
- R11: A one-cycle pulse on `alm_hit_i[n]` sets status bit n. A write to the status register loads bits 1:0 from the data byte. Status bits 1:0 are driven on `irq_flags_o`.
- R12: Locations 0x12 to 0x1F read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | Serial clock from host, idle low |
| spi_cs_i | input | 1 | Chip select, active high |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| ext_addr_o | output | 4 | Location within the external counter/alarm window |
| ext_we_o | output | 1 | One-cycle write strobe to the external window |
| ext_wdata_o | output | 8 | Write data to the external window |
| ext_rdata_i | input | 8 | Read data from the external window at `ext_addr_o` |
| alm_hit_i | input | 2 | Alarm match pulses that set the status flags |
| ctrl_o | output | 8 | Control register contents |
| irq_flags_o | output | 2 | Status flags |
| trickle_o | output | 8 | Trickle-charge configuration |

## Verification
The bench uses the default two-stage synchronizer and the default map, with the 96-byte RAM ending at 0x7F. Both wrap points can therefore be reached in a short burst: a three-byte write starting at 0x7E, and a three-byte read starting at 0x1E. With a serial clock of sixteen system clocks per bit, the synchronizer delay leaves MISO settled well before the host's falling-edge sample. The bench also drops chip select in the middle of a command byte and in the middle of a data byte, which covers the byte-framing recovery.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int AW         = 7;
  localparam int DW         = 8;
  localparam int RAM_DEPTH  = 96;
  localparam int EXT_SPAN   = 15;
  localparam int EXT_AW     = $clog2(EXT_SPAN);
  localparam int NUM_ALM    = 2;
  localparam int BIT_CNT_W  = $clog2(DW);

  localparam logic [AW-1:0] RAM_BASE = AW'((2 ** AW) - RAM_DEPTH);
  localparam logic [AW-1:0] RAM_LAST = AW'((2 ** AW) - 1);
  localparam logic [AW-1:0] CTRL_A   = 7'h0F;
  localparam logic [AW-1:0] STAT_A   = 7'h10;
  localparam logic [AW-1:0] TRKL_A   = 7'h11;

  localparam int            WP_BIT    = 6;
  localparam logic [DW-1:0] CTRL_KEEP = 8'hC7;
  localparam logic [3:0]    TRKL_KEY  = 4'hA;
  localparam logic [DW-1:0] TRKL_OFF  = 8'h00;

  typedef enum logic [2:0] {
    RG_EXT, RG_CTRL, RG_STAT, RG_TRKL, RG_RSVD, RG_RAM
  } region_e;

  function automatic region_e addr_region(input logic [AW-1:0] a);
    if (a < AW'(EXT_SPAN)) return RG_EXT;
    if (a == CTRL_A)       return RG_CTRL;
    if (a == STAT_A)       return RG_STAT;
    if (a == TRKL_A)       return RG_TRKL;
    if (a >= RAM_BASE)     return RG_RAM;
    return RG_RSVD;
  endfunction

  // increment that stays inside the RAM or inside the register block
  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    if (a == RAM_LAST)           return RAM_BASE;
    if (a == RAM_BASE - AW'(1))  return '0;
    return a + AW'(1);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_i,
  input  logic mosi_i,
  output logic cs_o,
  output logic mosi_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0]   sclk_sr;
  logic [STAGES-1:0] cs_sr;
  logic [STAGES-1:0] mosi_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sr <= '0;
      cs_sr   <= '0;
      mosi_sr <= '0;
    end else begin
      sclk_sr <= {sclk_sr[STAGES-1:0], sclk_i};
      cs_sr   <= {cs_sr[STAGES-2:0], cs_i};
      mosi_sr <= {mosi_sr[STAGES-2:0], mosi_i};
    end
  end

  // edge flags are aligned with the synchronized cs and mosi
  assign rise_o = sclk_sr[STAGES-1] & ~sclk_sr[STAGES];
  assign fall_o = ~sclk_sr[STAGES-1] & sclk_sr[STAGES];
  assign cs_o   = cs_sr[STAGES-1];
  assign mosi_o = mosi_sr[STAGES-1];
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_reg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          mosi_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          miso_o
);
  logic [BIT_CNT_W-1:0] bit_cnt_q;
  logic [DW-2:0]        rx_q;
  logic [DW-1:0]        tx_q;
  logic [AW-1:0]        addr_q;
  logic                 in_data_q;
  logic                 wr_dir_q;
  logic [DW-1:0]        byte_in;
  logic                 byte_done;

  assign byte_in   = {rx_q, mosi_i};
  assign byte_done = cs_i & fall_i & (bit_cnt_q == BIT_CNT_W'(DW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      in_data_q <= 1'b0;
      wr_dir_q  <= 1'b0;
    end else if (!cs_i) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      in_data_q <= 1'b0;
      wr_dir_q  <= 1'b0;
    end else begin
      if (fall_i) begin
        rx_q      <= byte_in[DW-2:0];
        bit_cnt_q <= bit_cnt_q + BIT_CNT_W'(1);
      end
      if (byte_done) begin
        if (!in_data_q) begin
          in_data_q <= 1'b1;
          wr_dir_q  <= byte_in[DW-1];
          addr_q    <= byte_in[AW-1:0];
        end else begin
          addr_q <= addr_next(addr_q);
        end
      end
      if (rise_i) begin
        if (bit_cnt_q == '0 && in_data_q && !wr_dir_q) tx_q <= rdata_i;
        else                                           tx_q <= {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  assign addr_o  = addr_q;
  assign wr_o    = byte_done & in_data_q & wr_dir_q;
  assign wdata_o = byte_in;
  assign miso_o  = tx_q[DW-1];
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_reg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_ALM-1:0] alm_hit_i,
  output logic [EXT_AW-1:0]  ext_addr_o,
  output logic               ext_we_o,
  output logic [DW-1:0]      ext_wdata_o,
  input  logic [DW-1:0]      ext_rdata_i,
  output logic [DW-1:0]      ctrl_o,
  output logic [NUM_ALM-1:0] flags_o,
  output logic [DW-1:0]      trickle_o
);
  logic [DW-1:0]      ctrl_q;
  logic [DW-1:0]      trkl_q;
  logic [NUM_ALM-1:0] flag_q;
  logic [DW-1:0]      ram_q [RAM_DEPTH];
  logic [AW-1:0]      ram_ofs;
  region_e            region;
  logic               wr_ok;

  assign region  = addr_region(addr_i);
  assign ram_ofs = addr_i - RAM_BASE;
  // the lock never blocks its own register
  assign wr_ok   = wr_i & (~ctrl_q[WP_BIT] | (region == RG_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      trkl_q <= TRKL_OFF;
    end else if (wr_ok) begin
      if (region == RG_CTRL) ctrl_q <= wdata_i & CTRL_KEEP;
      if (region == RG_TRKL) trkl_q <= (wdata_i[DW-1:4] == TRKL_KEY) ? wdata_i : TRKL_OFF;
    end
  end

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               flag_q[g] <= 1'b0;
      else if (alm_hit_i[g])                     flag_q[g] <= 1'b1;
      else if (wr_ok && region == RG_STAT)       flag_q[g] <= wdata_i[g];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok && region == RG_RAM) ram_q[ram_ofs] <= wdata_i;
  end

  always_comb begin
    unique case (region)
      RG_EXT:  rdata_o = ext_rdata_i;
      RG_CTRL: rdata_o = ctrl_q;
      RG_STAT: rdata_o = {{(DW-NUM_ALM){1'b0}}, flag_q};
      RG_TRKL: rdata_o = trkl_q;
      RG_RAM:  rdata_o = ram_q[ram_ofs];
      default: rdata_o = '0;
    endcase
  end

  assign ext_addr_o  = addr_i[EXT_AW-1:0];
  assign ext_we_o    = wr_ok & (region == RG_EXT);
  assign ext_wdata_o = wdata_i;
  assign ctrl_o      = ctrl_q;
  assign flags_o     = flag_q;
  assign trickle_o   = trkl_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic [3:0]        ext_addr_o,
  output logic              ext_we_o,
  output logic [7:0]        ext_wdata_o,
  input  logic [7:0]        ext_rdata_i,
  input  logic [1:0]        alm_hit_i,
  output logic [7:0]        ctrl_o,
  output logic [1:0]        irq_flags_o,
  output logic [7:0]        trickle_o
);
  logic          cs_s, mosi_s, sclk_rise, sclk_fall;
  logic [AW-1:0] acc_addr;
  logic          acc_wr;
  logic [DW-1:0] acc_wdata, acc_rdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(spi_sclk_i),
    .cs_i  (spi_cs_i),
    .mosi_i(spi_mosi_i),
    .cs_o  (cs_s),
    .mosi_o(mosi_s),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  spi_frame_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_s),
    .mosi_i (mosi_s),
    .rise_i (sclk_rise),
    .fall_i (sclk_fall),
    .rdata_i(acc_rdata),
    .addr_o (acc_addr),
    .wr_o   (acc_wr),
    .wdata_o(acc_wdata),
    .miso_o (spi_miso_o)
  );

  spi_reg_file u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (acc_addr),
    .wr_i       (acc_wr),
    .wdata_i    (acc_wdata),
    .rdata_o    (acc_rdata),
    .alm_hit_i  (alm_hit_i),
    .ext_addr_o (ext_addr_o),
    .ext_we_o   (ext_we_o),
    .ext_wdata_o(ext_wdata_o),
    .ext_rdata_i(ext_rdata_i),
    .ctrl_o     (ctrl_o),
    .flags_o    (irq_flags_o),
    .trickle_o  (trickle_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       spi_miso_o,
  input logic [3:0] ext_addr_o,
  input logic       ext_we_o,
  input logic [7:0] ctrl_o,
  input logic [7:0] trickle_o
);
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[5:3] == 3'b000);                                        // R7
  AST_LOCK_NO_EXT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> !ctrl_o[6]);                                      // R6
  AST_LOCK_KEEPS_TRKL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[6] |=> $stable(trickle_o));                             // R6
  AST_EXT_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> (ext_addr_o < 4'd15));                            // R10
  AST_EXT_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |=> !ext_we_o);                                       // R10
  AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !spi_miso_o);                                        // R5
  AST_TRKL_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trickle_o == 8'h00) || (trickle_o[7:4] == 4'hA));             // R8
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .spi_miso_o(spi_miso_o),
  .ext_addr_o(ext_addr_o),
  .ext_we_o  (ext_we_o),
  .ctrl_o    (ctrl_o),
  .trickle_o (trickle_o)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic       miso;
  logic [3:0] ext_addr;
  logic       ext_we;
  logic [7:0] ext_wdata, ext_rdata;
  logic [1:0] alm_hit = 2'b00;
  logic [7:0] ctrl, trickle;
  logic [1:0] flags;
  logic [7:0] ext_mem [15];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sclk_i(sclk), .spi_cs_i(cs), .spi_mosi_i(mosi), .spi_miso_o(miso),
    .ext_addr_o(ext_addr), .ext_we_o(ext_we), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata), .alm_hit_i(alm_hit),
    .ctrl_o(ctrl), .irq_flags_o(flags), .trickle_o(trickle)
  );

  // model of the external counter/alarm window
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 15; i++) ext_mem[i] <= 8'h10 + 8'(i);
    end else if (ext_we && ext_addr < 4'd15) begin
      ext_mem[ext_addr] <= ext_wdata;
    end
  end
  assign ext_rdata = (ext_addr < 4'd15) ? ext_mem[ext_addr] : 8'h00;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic spi_begin();
    @(negedge clk); cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (6) @(negedge clk);
    cs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); sclk = 1'b1; mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    spi_begin();
    spi_byte({1'b1, a}, r);
    spi_byte(d, r);
    spi_end();
  endtask

  task automatic reg_rd(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    spi_begin();
    spi_byte({1'b0, a}, r);
    spi_byte(8'h00, d);
    spi_end();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 ctrl reset", ctrl, 8'h00);
    chk("R8 trickle reset", trickle, 8'h00);
    chk("R11 flags reset", {6'b0, flags}, 8'h00);
    chk("R4 miso idle", {7'b0, miso}, 8'h00);
    reg_rd(7'h0F, d); chk("R7 ctrl read after reset", d, 8'h00);
  endtask

  task automatic t_ram_burst();
    logic [7:0] r, cmd_rx;
    spi_begin();
    spi_byte(8'hA0, r);                       // R1 write, start 0x20
    spi_byte(8'h3C, r); spi_byte(8'hC3, r); spi_byte(8'h81, r); spi_byte(8'h7E, r);
    spi_end();
    spi_begin();
    spi_byte(8'h20, cmd_rx);                  // R1 read, start 0x20
    chk("R4 miso low in command byte", cmd_rx, 8'h00);
    spi_byte(8'h00, r); chk("R9 ram 0x20", r, 8'h3C);
    spi_byte(8'h00, r); chk("R2 ram 0x21", r, 8'hC3);
    spi_byte(8'h00, r); chk("R2 ram 0x22", r, 8'h81);
    spi_byte(8'h00, r); chk("R2 ram 0x23", r, 8'h7E);
    spi_end();
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    spi_begin();
    spi_byte(8'hFE, r); spi_byte(8'h11, r); spi_byte(8'h22, r); spi_byte(8'h33, r);
    spi_end();
    reg_rd(7'h7F, r); chk("R3 ram 0x7F", r, 8'h22);
    reg_rd(7'h20, r); chk("R3 ram wrap to 0x20", r, 8'h33);
    spi_begin();
    spi_byte(8'h1E, r);
    spi_byte(8'h00, r); chk("R12 reserved 0x1E reads 0", r, 8'h00);
    spi_byte(8'h00, r); chk("R12 reserved 0x1F reads 0", r, 8'h00);
    spi_byte(8'h00, r); chk("R3 wrap 0x1F to 0x00", r, 8'h10);
    spi_end();
  endtask

  task automatic t_ext();
    logic [7:0] r;
    int pulses = 0;
    spi_begin();
    spi_byte(8'h85, r);
    fork
      begin spi_byte(8'hA1, r); spi_byte(8'hA2, r); end
      begin repeat (2 * 16 * HALF + 8) begin @(negedge clk); if (ext_we) pulses++; end end
    join
    spi_end();
    chk("R10 one strobe per byte", 8'(pulses), 8'd2);
    spi_begin();
    spi_byte(8'h05, r);
    spi_byte(8'h00, r); chk("R10 ext 0x05", r, 8'hA1);
    spi_byte(8'h00, r); chk("R10 ext 0x06", r, 8'hA2);
    spi_end();
  endtask

  task automatic t_lock();
    logic [7:0] r;
    reg_wr(7'h30, 8'h11);
    reg_wr(7'h0F, 8'hFF);
    reg_rd(7'h0F, r); chk("R7 ctrl reserved bits", r, 8'hC7);
    chk("R6 ctrl port", ctrl, 8'hC7);
    reg_wr(7'h30, 8'h99);
    reg_rd(7'h30, r); chk("R6 ram write blocked", r, 8'h11);
    reg_wr(7'h02, 8'h55);
    reg_rd(7'h02, r); chk("R6 ext write blocked", r, 8'h12);
    reg_wr(7'h11, 8'hA9);
    chk("R6 trickle write blocked", trickle, 8'h00);
    reg_wr(7'h0F, 8'h00);
    reg_rd(7'h0F, r); chk("R6 lock released", r, 8'h00);
    reg_wr(7'h30, 8'h99);
    reg_rd(7'h30, r); chk("R6 ram write after unlock", r, 8'h99);
  endtask

  task automatic t_trickle();
    logic [7:0] r;
    reg_wr(7'h11, 8'hA5);
    reg_rd(7'h11, r); chk("R8 keyed write", r, 8'hA5);
    chk("R8 trickle port", trickle, 8'hA5);
    reg_wr(7'h11, 8'h35);
    reg_rd(7'h11, r); chk("R8 unkeyed write disables", r, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] r;
    @(negedge clk); alm_hit = 2'b10;
    @(negedge clk); alm_hit = 2'b00;
    chk("R11 flag set by hit", {6'b0, flags}, 8'h02);
    reg_rd(7'h10, r); chk("R11 status read", r, 8'h02);
    reg_wr(7'h10, 8'hFD);
    reg_rd(7'h10, r); chk("R7 status upper bits zero", r, 8'h01);
    chk("R11 flags after write", {6'b0, flags}, 8'h01);
  endtask

  task automatic t_reserved();
    logic [7:0] r;
    reg_wr(7'h15, 8'h77);
    reg_rd(7'h15, r); chk("R12 reserved write ignored", r, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    reg_wr(7'h41, 8'h33);
    spi_begin(); spi_bits(8'hFF, 3, r); spi_end();     // partial command
    reg_wr(7'h40, 8'h5A);
    reg_rd(7'h40, r); chk("R5 realigned after partial command", r, 8'h5A);
    spi_begin();
    spi_byte(8'hC1, r); spi_bits(8'hEE, 5, r);           // partial data byte
    spi_end();
    reg_rd(7'h41, r); chk("R5 partial data byte dropped", r, 8'h33);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ram_burst();
    t_wrap();
    t_ext();
    t_lock();
    t_trickle();
    t_status();
    t_reserved();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule